// File: doc/BRIEF.md
# Coin-Operated Candy Vending Controller

This block is the control core of a candy vending machine. The price is fixed at 40 cents. The machine accepts nickels, dimes and quarters. A coin collector pulses one of three coin-deposit inputs for each coin. The controller keeps the accumulated credit as its state, in 5-cent steps from 0 to 60 cents. When the credit is exactly the price, the controller asks the candy dispenser for a bar. It then waits for the dispenser's delivery confirmation and goes back to zero credit.

Once the credit passes the price, the overshoot is paid back as change, largest coin first. The controller commands one coin at a time. It waits for the coin dispenser to confirm that the coin left before it lowers the credit by that coin's value. All control inputs are single-cycle synchronous pulses. The three command outputs are driven from a register, so they carry no combinational glitches. Every size and value is a parameter; the defaults give the 40-cent machine with 13 credit states.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the credit to 0 and drives all three command outputs low at the same clock edge.
- R2: While the credit is below 40 cents, a coin-deposit pulse raises the credit by the coin's value (nickel 5, dime 10, quarter 25), and all command outputs stay low.
- R3: When more than one coin-deposit input is high in one cycle, only one coin is counted: quarter before dime, dime before nickel.
- R4: With the credit at exactly 40 cents, `vend_candy` is high alone until a `candy_done` pulse, which returns the credit to 0.
- R5: With at least 10 cents above the price, `give_dime` is high, and a `dime_done` pulse lowers the credit by 10 cents.
- R6: With exactly 5 cents above the price, `give_nickel` is high, and a `nickel_done` pulse lowers the credit by 5 cents.
- R7: Any input that does not belong to the current state is ignored and leaves the credit unchanged. This covers coin deposits at or above the price, `candy_done` away from the price state, and a coin confirmation for the coin not being commanded.
- R8: The command outputs come from a register. They show the state the credit reached at the previous edge, so an input pulse sampled at edge k shows at the outputs after edge k+1. At most one command output is high at any time.
- R9: The highest credit is 60 cents (35 cents plus a quarter). From 60 cents the change is two dimes, returned one after the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle pulse: a nickel was deposited |
| coin_dime | input | 1 | One-cycle pulse: a dime was deposited |
| coin_quarter | input | 1 | One-cycle pulse: a quarter was deposited |
| nickel_done | input | 1 | One-cycle pulse: a change nickel was dispensed |
| dime_done | input | 1 | One-cycle pulse: a change dime was dispensed |
| candy_done | input | 1 | One-cycle pulse: a candy bar was delivered |
| give_nickel | output | 1 | Registered command: return one nickel |
| give_dime | output | 1 | Registered command: return one dime |
| vend_candy | output | 1 | Registered command: deliver one candy bar |

## Verification
An input pulse is sampled at one rising edge and moves the credit there. The command output that belongs to the new credit appears after the next rising edge, two edges after the pulse was driven. Each stimulus step therefore drives its pulse for one cycle, waits one further idle cycle, and samples the outputs on the falling edge that follows. A directed test also samples between those two edges, to show that the output has not yet moved. The reset result is due at the same edge that samples the reset, so it is checked on the next falling edge.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Registered command word toward the dispensers
  typedef struct packed {
    logic candy;
    logic dime;
    logic nickel;
  } vend_cmd_t;
endpackage

// File: rtl/vend_coin_sel.sv
// Picks one deposited coin per cycle (quarter > dime > nickel) and
// returns its value in credit units.
module vend_coin_sel #(
  parameter int W         = 4,
  parameter int NICKEL_U  = 1,
  parameter int DIME_U    = 2,
  parameter int QUARTER_U = 5
) (
  input  logic         coin_nickel,
  input  logic         coin_dime,
  input  logic         coin_quarter,
  output logic         coin_any,
  output logic [W-1:0] coin_units
);
  always_comb begin
    coin_any   = coin_nickel | coin_dime | coin_quarter;
    coin_units = '0;
    if (coin_quarter)     coin_units = W'(QUARTER_U);
    else if (coin_dime)   coin_units = W'(DIME_U);
    else if (coin_nickel) coin_units = W'(NICKEL_U);
  end
endmodule

// File: rtl/vend_credit_fsm.sv
// Credit state register: one state per credit step, 0 .. MAX_U.
module vend_credit_fsm #(
  parameter int W        = 4,
  parameter int PRICE_U  = 8,
  parameter int MAX_U    = 12,
  parameter int NICKEL_U = 1,
  parameter int DIME_U   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         coin_any,
  input  logic [W-1:0] coin_units,
  input  logic         nickel_done,
  input  logic         dime_done,
  input  logic         candy_done,
  output logic [W-1:0] credit
);
  localparam logic [W-1:0] PRICE_V  = W'(PRICE_U);
  localparam logic [W-1:0] MAX_V    = W'(MAX_U);
  localparam logic [W-1:0] NICKEL_V = W'(NICKEL_U);
  localparam logic [W-1:0] DIME_V   = W'(DIME_U);

  logic [W-1:0] credit_nx;
  logic [W:0]   sum_w;

  always_comb begin
    credit_nx = credit;
    sum_w     = {1'b0, credit} + {1'b0, coin_units};
    if (credit < PRICE_V) begin
      if (coin_any)
        credit_nx = (sum_w > {1'b0, MAX_V}) ? MAX_V : sum_w[W-1:0];
    end else if (credit == PRICE_V) begin
      if (candy_done) credit_nx = '0;
    end else if ((credit - PRICE_V) >= DIME_V) begin
      if (dime_done) credit_nx = credit - DIME_V;
    end else begin
      if (nickel_done) credit_nx = credit - NICKEL_V;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) credit <= '0;
    else     credit <= credit_nx;
  end

  // R2: a quarter below the price adds its value
  a_r2_quarter_adds: assert property (@(posedge clk) disable iff (rst)
    (credit < PRICE_V && coin_quarter_seen()) |=> credit == $past(credit) + W'(5));
  // R4/R7: the price state holds until the candy confirmation
  a_r7_price_hold: assert property (@(posedge clk) disable iff (rst)
    (credit == PRICE_V && !candy_done) |=> $stable(credit));
  // R4: candy confirmation returns to zero
  a_r4_candy_clears: assert property (@(posedge clk) disable iff (rst)
    (credit == PRICE_V && candy_done) |=> credit == '0);
  // R5: dime confirmation steps down by one dime
  a_r5_dime_step: assert property (@(posedge clk) disable iff (rst)
    (credit >= PRICE_V + DIME_V && dime_done) |=> credit == $past(credit) - DIME_V);
  // R9: credit never exceeds the ceiling
  a_r9_ceiling: assert property (@(posedge clk) disable iff (rst) credit <= MAX_V);

  function automatic logic coin_quarter_seen();
    return coin_any && coin_units == W'(5);
  endfunction
endmodule

// File: rtl/vend_out_stage.sv
// Decodes the credit into one command and registers it.
module vend_out_stage #(
  parameter int W       = 4,
  parameter int PRICE_U = 8,
  parameter int DIME_U  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       credit,
  output vend_pkg::vend_cmd_t cmd_q
);
  localparam logic [W-1:0] PRICE_V = W'(PRICE_U);
  localparam logic [W-1:0] DIME_V  = W'(DIME_U);

  vend_pkg::vend_cmd_t cmd_d;

  always_comb begin
    cmd_d = '0;
    if (credit == PRICE_V)                   cmd_d.candy  = 1'b1;
    else if (credit > PRICE_V) begin
      if ((credit - PRICE_V) >= DIME_V)      cmd_d.dime   = 1'b1;
      else                                   cmd_d.nickel = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else     cmd_q <= cmd_d;
  end

  // R8: never more than one command at once
  a_r8_one_command: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_q.candy, cmd_q.dime, cmd_q.nickel}));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int UNIT_CENTS    = 5,
  parameter int PRICE_CENTS   = 40,
  parameter int NICKEL_CENTS  = 5,
  parameter int DIME_CENTS    = 10,
  parameter int QUARTER_CENTS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_nickel,
  input  logic coin_dime,
  input  logic coin_quarter,
  input  logic nickel_done,
  input  logic dime_done,
  input  logic candy_done,
  output logic give_nickel,
  output logic give_dime,
  output logic vend_candy
);
  localparam int PRICE_U   = PRICE_CENTS / UNIT_CENTS;
  localparam int NICKEL_U  = NICKEL_CENTS / UNIT_CENTS;
  localparam int DIME_U    = DIME_CENTS / UNIT_CENTS;
  localparam int QUARTER_U = QUARTER_CENTS / UNIT_CENTS;
  localparam int MAX_U     = PRICE_U - NICKEL_U + QUARTER_U;
  localparam int W         = $clog2(MAX_U + 1);

  logic         coin_any;
  logic [W-1:0] coin_units;
  logic [W-1:0] credit;
  vend_pkg::vend_cmd_t cmd_q;

  vend_coin_sel #(.W(W), .NICKEL_U(NICKEL_U), .DIME_U(DIME_U), .QUARTER_U(QUARTER_U)) u_sel (
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .coin_quarter(coin_quarter),
    .coin_any    (coin_any),
    .coin_units  (coin_units)
  );

  vend_credit_fsm #(.W(W), .PRICE_U(PRICE_U), .MAX_U(MAX_U),
                    .NICKEL_U(NICKEL_U), .DIME_U(DIME_U)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .coin_any   (coin_any),
    .coin_units (coin_units),
    .nickel_done(nickel_done),
    .dime_done  (dime_done),
    .candy_done (candy_done),
    .credit     (credit)
  );

  vend_out_stage #(.W(W), .PRICE_U(PRICE_U), .DIME_U(DIME_U)) u_out (
    .clk   (clk),
    .rst   (rst),
    .credit(credit),
    .cmd_q (cmd_q)
  );

  assign give_nickel = cmd_q.nickel;
  assign give_dime   = cmd_q.dime;
  assign vend_candy  = cmd_q.candy;

  // R1: reset leaves all commands low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !(give_nickel || give_dime || vend_candy));
  // R8: the candy command follows the price state one edge later
  a_r8_candy_lag: assert property (@(posedge clk) disable iff (rst)
    (credit == W'(PRICE_U)) |=> vend_candy);
endmodule

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
  localparam int CLK_PERIOD = 10;

  // input word {candy_done, dime_done, nickel_done, quarter, dime, nickel}
  localparam logic [5:0] I_N  = 6'b000001;
  localparam logic [5:0] I_D  = 6'b000010;
  localparam logic [5:0] I_Q  = 6'b000100;
  localparam logic [5:0] I_NO = 6'b001000;
  localparam logic [5:0] I_DO = 6'b010000;
  localparam logic [5:0] I_CO = 6'b100000;
  // expected word {vend_candy, give_dime, give_nickel}
  localparam logic [2:0] E_Z = 3'b000;
  localparam logic [2:0] E_C = 3'b100;
  localparam logic [2:0] E_D = 3'b010;
  localparam logic [2:0] E_N = 3'b001;

  localparam int NV = 43;
  // entry {requirement number, inputs, expected outputs}
  localparam logic [12:0] VEC [NV] = '{
    {4'd2, I_Q, E_Z},  {4'd5, I_Q, E_D},                 // R2 25, R5 50
    {4'd7, I_NO, E_D}, {4'd7, I_CO, E_D}, {4'd7, I_N, E_D}, // R7 ignored at 50
    {4'd5, I_DO, E_C},                                    // R5 -> 40
    {4'd7, I_Q, E_C},  {4'd7, I_DO, E_C},                 // R7 ignored at 40
    {4'd4, I_CO, E_Z},                                    // R4 -> 0
    {4'd2, I_D, E_Z},  {4'd2, I_D, E_Z}, {4'd2, I_D, E_Z}, // 30
    {4'd5, I_Q, E_D},  {4'd6, I_DO, E_N},                 // 55 -> 45
    {4'd7, I_DO, E_N}, {4'd6, I_NO, E_C}, {4'd4, I_CO, E_Z}, // R6 -> 40 -> 0
    {4'd3, I_Q|I_D|I_N, E_Z}, {4'd3, I_D|I_N, E_Z},       // R3 25, 35
    {4'd3, I_N, E_C},  {4'd4, I_CO, E_Z},
    {4'd2, I_D, E_Z},  {4'd2, I_N, E_Z},                  // 15
    {4'd7, I_CO, E_Z}, {4'd7, I_DO, E_Z}, {4'd7, I_NO, E_Z},
    {4'd7, I_Q, E_C},  {4'd4, I_CO, E_Z},                 // 15 kept -> 40
    {4'd2, I_D, E_Z},  {4'd2, I_Q, E_Z},                  // 35
    {4'd9, I_Q, E_D},  {4'd9, I_DO, E_D}, {4'd9, I_DO, E_C}, // R9 60 -> 50 -> 40
    {4'd4, I_CO, E_Z},
    {4'd2, I_N, E_Z},  {4'd2, I_N, E_Z}, {4'd2, I_N, E_Z}, {4'd2, I_N, E_Z},
    {4'd2, I_N, E_Z},  {4'd2, I_N, E_Z}, {4'd2, I_N, E_Z},
    {4'd4, I_N, E_C},  {4'd4, I_CO, E_Z}
  };

  logic clk = 1'b0;
  logic rst;
  logic [5:0] drv;
  logic give_nickel, give_dime, vend_candy;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl uut (
    .clk(clk), .rst(rst),
    .coin_nickel(drv[0]), .coin_dime(drv[1]), .coin_quarter(drv[2]),
    .nickel_done(drv[3]), .dime_done(drv[4]), .candy_done(drv[5]),
    .give_nickel(give_nickel), .give_dime(give_dime), .vend_candy(vend_candy)
  );

  task automatic check(input logic [2:0] exp, input int req, input int idx);
    logic [2:0] act;
    act = {vend_candy, give_dime, give_nickel};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d step %0d: got %b expected %b", req, idx, act, exp);
    end
  endtask

  // pulse for one cycle, idle one cycle, sample on the falling edge
  task automatic step(input logic [5:0] in, input logic [2:0] exp, input int req, input int idx);
    drv = in;
    @(negedge clk);
    drv = '0;
    @(negedge clk);
    check(exp, req, idx);
  endtask

  initial begin
    rst = 1'b1;
    drv = '0;
    repeat (3) @(negedge clk);
    check(E_Z, 1, 0);                           // R1 reset state
    rst = 1'b0;
    @(negedge clk);
    check(E_Z, 1, 1);                           // R1 credit 0, idle

    for (int i = 0; i < NV; i++)
      step(VEC[i][8:3], VEC[i][2:0], int'(VEC[i][12:9]), 100 + i);

    // R8: output latency, credit 25 -> 50
    step(I_Q, E_Z, 2, 200);
    drv = I_Q;
    @(negedge clk);
    drv = '0;
    check(E_Z, 8, 201);                         // r8_ not yet after first edge
    @(negedge clk);
    check(E_D, 8, 202);                         // r8_ due after second edge

    // R1: reset in the change state, then credit restarts at 0
    rst = 1'b1;
    @(negedge clk);
    check(E_Z, 1, 203);
    rst = 1'b0;
    step(I_Q, E_Z, 1, 204);                     // 25, not 75
    step(I_Q, E_D, 1, 205);                     // 50
    step(I_DO, E_C, 5, 206);
    step(I_CO, E_Z, 4, 207);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule